// File: doc/BRIEF.md
# PHY Management Interrupt Unit

This block collects status-change interrupts for the management register file of a physical-layer device. Nine live status conditions are watched. When one of them changes level, in either direction, its bit in the status word captures the new level and freezes there. It also becomes a pending interrupt, unless its mask bit is set. The block reports a pending interrupt in three ways. The summary interrupt bit goes high, the active-low interrupt pin goes low, and, if the in-band scheme is selected, one low pulse is driven onto the MDIO line while MDC is high.

A status read, given as a one-cycle strobe from the serial management engine, clears every pending interrupt. It also reloads each status bit with its present live level. The engine's busy flag defers the in-band pulse. When an access ends, the block lets one further MDC rising edge go by and then drives the pulse on the next high phase. Between pulses the line is released to high impedance, and an external pull-up holds it high. MDC is sampled in the block's own clock domain, and so are the live status inputs.

The in-band pulse is sequenced by a six-state machine:
- PS_IDLE: no pulse is owed.
- PS_WAIT: waiting for an MDC rising edge while the port is idle.
- PS_DEFER: an access is in progress.
- PS_GAP: the access has ended and the block is letting one MDC rising edge pass.
- PS_DRIVE: the pulse is on the line.
- PS_SENT: the pulse has gone out and the block waits for a read.

The transitions are as follows:
- PS_IDLE goes to PS_WAIT when an interrupt is pending and the scheme is selected, or to PS_DEFER if the port is also busy.
- PS_WAIT goes to PS_DEFER on busy and to PS_DRIVE on an MDC rising edge.
- PS_DEFER goes to PS_GAP when busy drops.
- PS_GAP goes to PS_DEFER on busy and to PS_WAIT on an MDC rising edge.
- PS_DRIVE goes to PS_SENT on an MDC falling edge.
- PS_SENT goes to PS_IDLE on a status read.
- PS_WAIT, PS_DEFER and PS_GAP fall back to PS_IDLE when nothing is pending any more or the scheme is deselected.

Top module: `mgmt_irq_top`

## Requirements
- R1: During and after a synchronous reset with steady inputs, the following hold. Bits 14 down to 6 of `stat_word` equal `live_stat`, `int_bit` is 0, `mdint_n` is 1 and `mdio_oe` is 0.
- R2: A level change on an unmasked `live_stat[i]` appears within six clock cycles. Bit 6+i of `stat_word` takes the new level, `int_bit` becomes 1 and `mdint_n` becomes 0. The bit keeps the captured level even if the live input changes again before a read.
- R3: A one-cycle `stat_rd` strobe clears all pending interrupts, so `int_bit` becomes 0 and `mdint_n` becomes 1. It also reloads every field bit with the current synchronized live level.
- R4: When `irq_mask[i]` is 1, the field bit follows the live level and raises no interrupt. Setting the mask bit also removes an interrupt that bit already has pending.
- R5: With `pulse_sel` set, a pending interrupt produces one MDIO pulse: `mdio_oe` = 1 with `mdio_o` = 0, for exactly one MDC high phase. The pulse starts after an MDC rising edge and ends after the following falling edge.
- R6: With `pulse_sel` clear, `mdio_oe` stays 0 whatever the interrupts do.
- R7: While `port_busy` is 1, no pulse starts. After busy falls, the first MDC rising edge is skipped, and the pulse begins after the second one.
- R8: After the pulse, further status changes before the next `stat_rd` give no more pulses. After a read, a new change gives a new pulse.
- R9: Bits 15 and 5 down to 0 of `stat_word` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| live_stat | input | 9 | Live status conditions, asynchronous |
| irq_mask | input | 9 | Per-bit interrupt mask, 1 = masked |
| pulse_sel | input | 1 | Selects the in-band MDIO pulse scheme |
| mdc | input | 1 | Management clock, sampled |
| port_busy | input | 1 | Serial port access in progress |
| stat_rd | input | 1 | One-cycle strobe: status word read |
| stat_word | output | 16 | Status word, latched field at bits 14:6 |
| int_bit | output | 1 | Summary interrupt bit |
| mdint_n | output | 1 | Active-low interrupt pin |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_o | output | 1 | MDIO drive value |

## Verification
The bench builds the block with its default parameters: nine interrupt bits, a 16-bit word with the field at bit 6, and two synchronizer stages. It runs MDC at one sixteenth of the block clock. This fixes the pulse width at eight cycles. It also leaves room to drop the busy flag in the middle of a low phase, so the count of skipped MDC edges is unambiguous. Nine bits keep random mask and read patterns dense enough to hit masked-while-pending and change-after-capture cases often.

// File: rtl/mgmt_irq_pkg.sv
package mgmt_irq_pkg;

    typedef enum logic [2:0] {
        PS_IDLE  = 3'd0,
        PS_WAIT  = 3'd1,
        PS_DEFER = 3'd2,
        PS_GAP   = 3'd3,
        PS_DRIVE = 3'd4,
        PS_SENT  = 3'd5
    } pulse_state_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    stage_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
    parameter int N_IRQ = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] live_s,
    input  logic [N_IRQ-1:0] mask,
    input  logic             rd,
    output logic [N_IRQ-1:0] lat,
    output logic [N_IRQ-1:0] pend
);

    generate
        for (genvar i = 0; i < N_IRQ; i++) begin : g_bit
            logic lat_q;
            logic pend_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lat_q  <= live_s[i];
                    pend_q <= 1'b0;
                end else if (mask[i] || rd) begin
                    lat_q  <= live_s[i];
                    pend_q <= 1'b0;
                end else if (!pend_q && (live_s[i] != lat_q)) begin
                    lat_q  <= live_s[i];
                    pend_q <= 1'b1;
                end
            end

            assign lat[i]  = lat_q;
            assign pend[i] = pend_q;
        end
    endgenerate

endmodule

// File: rtl/mdio_pulse_fsm.sv
module mdio_pulse_fsm
    import mgmt_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_any,
    input  logic pulse_sel,
    input  logic busy,
    input  logic rd,
    input  logic mdc_rise,
    input  logic mdc_fall,
    output logic mdio_oe,
    output logic mdio_o
);

    pulse_state_t state_q;
    pulse_state_t state_d;
    logic         owed;

    assign owed = irq_any && pulse_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: begin
                if (owed) begin
                    state_d = busy ? PS_DEFER : PS_WAIT;
                end
            end
            PS_WAIT: begin
                if (!owed) begin
                    state_d = PS_IDLE;
                end else if (busy) begin
                    state_d = PS_DEFER;
                end else if (mdc_rise) begin
                    state_d = PS_DRIVE;
                end
            end
            PS_DEFER: begin
                if (!owed) begin
                    state_d = PS_IDLE;
                end else if (!busy) begin
                    state_d = PS_GAP;
                end
            end
            PS_GAP: begin
                if (!owed) begin
                    state_d = PS_IDLE;
                end else if (busy) begin
                    state_d = PS_DEFER;
                end else if (mdc_rise) begin
                    state_d = PS_WAIT;
                end
            end
            PS_DRIVE: begin
                if (mdc_fall) begin
                    state_d = PS_SENT;
                end
            end
            PS_SENT: begin
                if (rd) begin
                    state_d = PS_IDLE;
                end
            end
            default: state_d = PS_IDLE;
        endcase
    end

    always_comb begin
        mdio_oe = 1'b0;
        mdio_o  = 1'b1;
        unique case (state_q)
            PS_DRIVE: begin
                mdio_oe = 1'b1;
                mdio_o  = 1'b0;
            end
            PS_IDLE, PS_WAIT, PS_DEFER, PS_GAP, PS_SENT: begin
                mdio_oe = 1'b0;
                mdio_o  = 1'b1;
            end
            default: begin
                mdio_oe = 1'b0;
                mdio_o  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mgmt_irq_top.sv
module mgmt_irq_top #(
    parameter int N_IRQ       = 9,
    parameter int WORD_W      = 16,
    parameter int FIELD_LSB   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  live_stat,
    input  logic [N_IRQ-1:0]  irq_mask,
    input  logic              pulse_sel,
    input  logic              mdc,
    input  logic              port_busy,
    input  logic              stat_rd,
    output logic [WORD_W-1:0] stat_word,
    output logic              int_bit,
    output logic              mdint_n,
    output logic              mdio_oe,
    output logic              mdio_o
);

    localparam int FIELD_MSB = FIELD_LSB + N_IRQ - 1;

    logic [N_IRQ-1:0] live_s;
    logic [N_IRQ-1:0] lat;
    logic [N_IRQ-1:0] pend;
    logic             mdc_s;
    logic             mdc_q;
    logic             mdc_rise;
    logic             mdc_fall;
    logic             irq_any;

    irq_sync #(.WIDTH(N_IRQ), .STAGES(SYNC_STAGES)) u_live_sync (
        .clk (clk),
        .d   (live_stat),
        .q   (live_s)
    );

    irq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_mdc_sync (
        .clk (clk),
        .d   (mdc),
        .q   (mdc_s)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_q <= mdc_s;
        end else begin
            mdc_q <= mdc_s;
        end
    end

    assign mdc_rise = mdc_s && !mdc_q && rst_n;
    assign mdc_fall = !mdc_s && mdc_q && rst_n;

    irq_latch_bank #(.N_IRQ(N_IRQ)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .live_s (live_s),
        .mask   (irq_mask),
        .rd     (stat_rd),
        .lat    (lat),
        .pend   (pend)
    );

    assign irq_any = |pend;
    assign int_bit = irq_any;
    assign mdint_n = !irq_any;

    always_comb begin
        stat_word = '0;
        stat_word[FIELD_MSB:FIELD_LSB] = lat;
    end

    mdio_pulse_fsm u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_any   (irq_any),
        .pulse_sel (pulse_sel),
        .busy      (port_busy),
        .rd        (stat_rd),
        .mdc_rise  (mdc_rise),
        .mdc_fall  (mdc_fall),
        .mdio_oe   (mdio_oe),
        .mdio_o    (mdio_o)
    );

endmodule

// File: rtl/mgmt_irq_chk.sv
module mgmt_irq_chk #(
    parameter int N_IRQ = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IRQ-1:0] irq_mask,
    input logic             pulse_sel,
    input logic             port_busy,
    input logic             stat_rd,
    input logic             mdint_n,
    input logic             mdio_oe
);

    // R4
    all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&irq_mask) |=> mdint_n);

    // R2
    hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mdint_n && !stat_rd && (irq_mask == '0)) |=> !mdint_n);

    // R5
    pulse_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> $past(pulse_sel));

    // R5
    pulse_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> $past(!mdint_n));

    // R7
    pulse_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> $past(!port_busy));

endmodule

bind mgmt_irq_top mgmt_irq_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_mask  (irq_mask),
    .pulse_sel (pulse_sel),
    .port_busy (port_busy),
    .stat_rd   (stat_rd),
    .mdint_n   (mdint_n),
    .mdio_oe   (mdio_oe)
);

// File: tb/mgmt_irq_top_test.sv
`timescale 1ns/1ps
module mgmt_irq_top_test;

    localparam int N = 9;
    localparam int HALF_MDC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  live_stat = '0;
    logic [N-1:0]  irq_mask = '0;
    logic          pulse_sel = 1'b0;
    logic          mdc = 1'b0;
    logic          port_busy = 1'b0;
    logic          stat_rd = 1'b0;
    logic [15:0]   stat_word;
    logic          int_bit;
    logic          mdint_n;
    logic          mdio_oe;
    logic          mdio_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int mdc_cnt = 0;

    logic [N-1:0] m_lat;
    logic [N-1:0] m_pend;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (mdc_cnt == HALF_MDC - 1) begin
            mdc_cnt <= 0;
            mdc <= ~mdc;
        end else begin
            mdc_cnt <= mdc_cnt + 1;
        end
    end

    mgmt_irq_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .live_stat (live_stat),
        .irq_mask  (irq_mask),
        .pulse_sel (pulse_sel),
        .mdc       (mdc),
        .port_busy (port_busy),
        .stat_rd   (stat_rd),
        .stat_word (stat_word),
        .int_bit   (int_bit),
        .mdint_n   (mdint_n),
        .mdio_oe   (mdio_oe),
        .mdio_o    (mdio_o)
    );

    function automatic logic [15:0] exp_word(input logic [N-1:0] l);
        logic [15:0] w;
        w = '0;
        w[14:6] = l;
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_change();
        for (int i = 0; i < N; i++) begin
            if (irq_mask[i]) begin
                m_lat[i] = live_stat[i];
                m_pend[i] = 1'b0;
            end else if (!m_pend[i] && (live_stat[i] != m_lat[i])) begin
                m_lat[i] = live_stat[i];
                m_pend[i] = 1'b1;
            end
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
        model_change();
    endtask

    task automatic do_read();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        m_lat = live_stat;
        m_pend = '0;
        @(negedge clk);
        model_change();
    endtask

    task automatic check_state(input string req);
        check(req, {16'h0, stat_word}, {16'h0, exp_word(m_lat)});
        check(req, {31'h0, int_bit}, {31'h0, |m_pend});
        check(req, {31'h0, mdint_n}, {31'h0, ~|m_pend});
    endtask

    task automatic watch(input int n, output int pulses, output int maxw, output int lowbad);
        int w;
        logic prev;
        pulses = 0;
        maxw = 0;
        lowbad = 0;
        w = 0;
        prev = mdio_oe;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (mdio_oe && !prev) pulses++;
            if (mdio_oe) begin
                w++;
                if (mdio_o !== 1'b0) lowbad++;
            end else begin
                if (w > maxw) maxw = w;
                w = 0;
            end
            prev = mdio_oe;
        end
        if (w > maxw) maxw = w;
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int pulses;
        int maxw;
        int lowbad;
        int rises;
        logic pm;
        void'($urandom(32'h5eed_1234));
        live_stat = N'($urandom);
        repeat (10) @(negedge clk);
        m_lat = live_stat;
        m_pend = '0;
        check("R1", {31'h0, mdio_oe}, 32'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_state("R1");
        check("R1", {31'h0, mdio_oe}, 32'h0);
        check("R9", {16'h0, stat_word & 16'h803f}, 32'h0);

        // R2: change bit 3 in one direction, then revert before read
        live_stat[3] = ~live_stat[3];
        settle();
        check_state("R2");
        check("R2", {31'h0, int_bit}, 32'h1);
        live_stat[3] = ~live_stat[3];
        settle();
        check_state("R2");
        check("R2", {31'h0, stat_word[9]}, {31'h0, ~live_stat[3]});
        // R3: read clears and reloads
        do_read();
        check_state("R3");
        check("R3", {31'h0, mdint_n}, 32'h1);

        // R4: masked bit follows live, no interrupt
        irq_mask[5] = 1'b1;
        live_stat[5] = ~live_stat[5];
        settle();
        check_state("R4");
        check("R4", {31'h0, stat_word[11]}, {31'h0, live_stat[5]});
        live_stat[0] = ~live_stat[0];
        settle();
        check("R4", {31'h0, mdint_n}, 32'h0);
        irq_mask[0] = 1'b1;
        settle();
        check_state("R4");
        check("R4", {31'h0, mdint_n}, 32'h1);
        irq_mask = '0;
        settle();
        do_read();

        // random phase, in-band scheme off (R6)
        for (int s = 0; s < 400; s++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 5) begin
                live_stat[$urandom_range(0, N-1)] ^= 1'b1;
                if (op == 0) live_stat[$urandom_range(0, N-1)] ^= 1'b1;
            end else if (op < 7) begin
                irq_mask[$urandom_range(0, N-1)] ^= 1'b1;
            end
            if (op >= 7) begin
                do_read();
            end else begin
                settle();
            end
            check_state(op >= 7 ? "R3" : (op >= 5 ? "R4" : "R2"));
            check("R6", {31'h0, mdio_oe}, 32'h0);
            check("R9", {16'h0, stat_word & 16'h803f}, 32'h0);
        end

        // R5 / R8: pulse scheme
        irq_mask = '0;
        settle();
        do_read();
        pulse_sel = 1'b1;
        live_stat[2] = ~live_stat[2];
        watch(100, pulses, maxw, lowbad);
        check("R5", pulses, 1);
        check("R5", maxw, HALF_MDC);
        check("R5", lowbad, 0);
        model_change();
        live_stat[7] = ~live_stat[7];
        watch(100, pulses, maxw, lowbad);
        check("R8", pulses, 0);
        model_change();
        check_state("R8");
        do_read();
        live_stat[7] = ~live_stat[7];
        watch(100, pulses, maxw, lowbad);
        check("R8", pulses, 1);
        model_change();
        do_read();

        // R7: deferral while busy
        port_busy = 1'b1;
        live_stat[4] = ~live_stat[4];
        watch(120, pulses, maxw, lowbad);
        check("R7", pulses, 0);
        @(negedge mdc);
        repeat (3) @(negedge clk);
        port_busy = 1'b0;
        rises = 0;
        pulses = 0;
        pm = mdc;
        for (int c = 0; c < 100 && pulses == 0; c++) begin
            @(negedge clk);
            if (mdc && !pm) rises++;
            pm = mdc;
            if (mdio_oe) pulses = 1;
        end
        check("R7", pulses, 1);
        check("R7", rises, 2);
        model_change();
        do_read();
        check_state("R3");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule